// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Resolver

This block arbitrates the hardware interrupts of a small 16-bit processor core. Sixteen maskable sources each own a 4-bit control register. The register holds a programmable 3-bit priority level and a pending-request flag. A raw request pulse from the peripheral sets the flag, and software can set or clear it through the register port. Three non-maskable requests (reset, debug, watchdog) rank above the whole maskable group in a fixed order.

The core raises an opcode-fetch strobe. On that strobe the block freezes a snapshot of every request flag, every level, the non-maskable inputs, the processor's current priority level and its interrupt-disable flag. In the next cycle a serial chain of compare stages resolves the snapshot. Each stage passes down either its own level or the level from above, and the upstream stage keeps a tie. The chain winner is then tested against the frozen processor state. On acceptance the block pulses accept, the set-disable command and the save-status command for one cycle. It reports the vector index and the new priority level, and it clears the winner's request flag. After each sample, further fetch strobes are ignored for two cycles.

Top module: `irq_prio_resolver`

## Requirements
- R1: Source i (0..15) has its control register at byte address 0x70+i. The sources in index order are A-D conversion, UART0 tx, UART0 rx, UART1 tx, UART1 rx, timer A0..A4, timer B0..B2, then INT0..INT2. A write stores bits 2:0 as the level and bit 3 as the request flag. A read returns the same 4-bit layout, and an address outside 0x70..0x7F reads 0.
- R2: A one-cycle pulse on src_req[i] sets request flag i. A register write can set or clear the flag, and a hardware pulse wins over a write or a clear in the same cycle.
- R3: The chain winner is the pending source with the highest nonzero level. A pending source with level 0 never wins.
- R4: Among equal levels, the source earlier in chain order wins. Chain order by source index is 0, 3, 4, 1, 2, 12, 11, 10, 9, 8, 7, 6, 5, 15, 14, 13.
- R5: A maskable winner is accepted only when its level is strictly greater than cpu_ipl and cpu_iflag is 0.
- R6: The non-maskable requests ignore cpu_iflag and cpu_ipl and rank above every maskable source, in the order reset, debug, watchdog. Their vector indices are 18, 17 and 16, and the new priority levels they report are 0, 7 and 7.
- R7: An acceptance gives accept, set_iflag and save_ps high together for exactly one cycle. For a maskable source, vec_idx is the source index and new_ipl is its level. The accepted source's request flag is cleared, and other flags are left as they were.
- R8: When opfetch is high in cycle T and the block is idle, the inputs are sampled at the end of T, and the result appears during T+2. Changes to flags, cpu_ipl or cpu_iflag after the sample do not alter that result.
- R9: opfetch is ignored in the two cycles after a sample, and it is honoured again in the third.
- R10: After reset every control register reads 0 and accept is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 4 | Write data {request, level} |
| reg_rdata | output | 4 | Read data of the addressed register |
| src_req | input | 16 | Hardware request pulses, one per source |
| nmi_reset | input | 1 | Reset request |
| nmi_debug | input | 1 | Debug request |
| nmi_wdog | input | 1 | Watchdog request |
| cpu_ipl | input | 3 | Current processor priority level |
| cpu_iflag | input | 1 | Current interrupt-disable flag |
| opfetch | input | 1 | Opcode-fetch sampling strobe |
| accept | output | 1 | Interrupt accepted (one-cycle pulse) |
| vec_idx | output | 5 | Accepted vector index |
| new_ipl | output | 3 | Priority level to load |
| set_iflag | output | 1 | Command to set the disable flag |
| save_ps | output | 1 | Command to save the status register |

## Verification
The bench targets equal-level ties at both ends of the chain and in the middle. A stage that compares with greater-or-equal lets the downstream source win those ties. It also targets a winner whose level equals the processor level, which an inclusive compare would wrongly accept, and pending sources at level 0, which a missing level-zero guard would let win. A burst of four back-to-back fetch strobes must give exactly two acceptances, because a design without the blackout would sample again and deliver extra or reordered vectors. A test that raises the disable flag and clears the flag bit just after the sample finds any design that resolves from live inputs instead of the frozen snapshot.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 16;
    localparam int SRC_W = $clog2(NSRC);
    localparam int LVL_W = 3;
    localparam int REG_W = LVL_W + 1;
    localparam int VEC_W = 5;

    localparam logic [VEC_W-1:0] VEC_WDOG  = VEC_W'(NSRC);
    localparam logic [VEC_W-1:0] VEC_DEBUG = VEC_W'(NSRC + 1);
    localparam logic [VEC_W-1:0] VEC_RESET = VEC_W'(NSRC + 2);
    localparam logic [LVL_W-1:0] IPL_RESET = '0;
    localparam logic [LVL_W-1:0] IPL_NMI   = '1;

    // Source index found at each chain position, top of the chain first.
    function automatic int chain_src(input int pos);
        case (pos)
            0: return 0;   1: return 3;   2: return 4;   3: return 1;
            4: return 2;   5: return 12;  6: return 11;  7: return 10;
            8: return 9;   9: return 8;   10: return 7;  11: return 6;
            12: return 5;  13: return 15; 14: return 14; default: return 13;
        endcase
    endfunction
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_pkg::*;
#(
    parameter logic [7:0] BASE = 8'h70
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [7:0]                    addr,
    input  logic [REG_W-1:0]              wdata,
    output logic [REG_W-1:0]              rdata,
    input  logic [NSRC-1:0]               hw_set,
    input  logic                          clr_en,
    input  logic [SRC_W-1:0]              clr_idx,
    output logic [NSRC-1:0]               req_o,
    output logic [NSRC-1:0][LVL_W-1:0]    lvl_o
);
    typedef struct packed {
        logic [NSRC-1:0]            req;
        logic [NSRC-1:0][LVL_W-1:0] lvl;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < NSRC; i++) begin
            if (wr_en && addr == 8'(int'(BASE) + i)) begin
                d.lvl[i] = wdata[LVL_W-1:0];
                d.req[i] = wdata[LVL_W];
            end else if (clr_en && clr_idx == SRC_W'(i)) begin
                d.req[i] = 1'b0;
            end
            if (hw_set[i]) d.req[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSRC; i++)
            if (addr == 8'(int'(BASE) + i)) rdata = {q.req[i], q.lvl[i]};
    end

    assign req_o = q.req;
    assign lvl_o = q.lvl;

    for (genvar g = 0; g < NSRC; g++) begin : g_set_chk
        // R2
        hw_set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[g] |=> q.req[g]);
    end
endmodule

// File: rtl/irq_chain_stage.sv
module irq_chain_stage
    import irq_pkg::*;
#(
    parameter int OWN_IDX = 0
) (
    input  logic [LVL_W-1:0] up_lvl,
    input  logic [VEC_W-1:0] up_idx,
    input  logic             own_req,
    input  logic [LVL_W-1:0] own_lvl,
    output logic [LVL_W-1:0] dn_lvl,
    output logic [VEC_W-1:0] dn_idx
);
    logic claim;

    always_comb begin
        claim = own_req && (own_lvl > up_lvl);
        dn_lvl = claim ? own_lvl : up_lvl;
        dn_idx = claim ? VEC_W'(OWN_IDX) : up_idx;
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_pkg::*;
#(
    parameter int         BLACKOUT = 2,
    parameter logic [7:0] REG_BASE = 8'h70
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [7:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NSRC-1:0]     src_req,
    input  logic                nmi_reset,
    input  logic                nmi_debug,
    input  logic                nmi_wdog,
    input  logic [LVL_W-1:0]    cpu_ipl,
    input  logic                cpu_iflag,
    input  logic                opfetch,
    output logic                accept,
    output logic [VEC_W-1:0]    vec_idx,
    output logic [LVL_W-1:0]    new_ipl,
    output logic                set_iflag,
    output logic                save_ps
);
    localparam int CNT_W = $clog2(BLACKOUT + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BLACKOUT);

    typedef struct packed {
        logic [NSRC-1:0]            sreq;
        logic [NSRC-1:0][LVL_W-1:0] slvl;
        logic [2:0]                 snmi;
        logic [LVL_W-1:0]           sipl;
        logic                       si;
        logic [CNT_W-1:0]           cnt;
        logic                       acc;
        logic [VEC_W-1:0]           vec;
        logic [LVL_W-1:0]           nipl;
    } st_t;

    st_t q, d;

    logic [NSRC-1:0]            live_req;
    logic [NSRC-1:0][LVL_W-1:0] live_lvl;
    logic                       clr_en;
    logic [SRC_W-1:0]           clr_idx;

    irq_ctrl_regs #(.BASE(REG_BASE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .hw_set  (src_req),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .req_o   (live_req),
        .lvl_o   (live_lvl)
    );

    logic [NSRC:0][LVL_W-1:0] ch_lvl;
    logic [NSRC:0][VEC_W-1:0] ch_idx;

    assign ch_lvl[0] = '0;
    assign ch_idx[0] = '0;

    for (genvar p = 0; p < NSRC; p++) begin : g_chain
        localparam int S = chain_src(p);
        irq_chain_stage #(.OWN_IDX(S)) u_stage (
            .up_lvl  (ch_lvl[p]),
            .up_idx  (ch_idx[p]),
            .own_req (q.sreq[S]),
            .own_lvl (q.slvl[S]),
            .dn_lvl  (ch_lvl[p+1]),
            .dn_idx  (ch_idx[p+1])
        );
    end

    logic [LVL_W-1:0] win_lvl;
    logic [VEC_W-1:0] win_idx;
    assign win_lvl = ch_lvl[NSRC];
    assign win_idx = ch_idx[NSRC];

    always_comb begin
        d       = q;
        d.acc   = 1'b0;
        clr_en  = 1'b0;
        clr_idx = '0;

        if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end else if (opfetch) begin
            d.sreq = live_req;
            d.slvl = live_lvl;
            d.snmi = {nmi_reset, nmi_debug, nmi_wdog};
            d.sipl = cpu_ipl;
            d.si   = cpu_iflag;
            d.cnt  = CNT_TOP;
        end

        if (q.cnt == CNT_TOP) begin
            if (q.snmi[2]) begin
                d.acc = 1'b1; d.vec = VEC_RESET; d.nipl = IPL_RESET;
            end else if (q.snmi[1]) begin
                d.acc = 1'b1; d.vec = VEC_DEBUG; d.nipl = IPL_NMI;
            end else if (q.snmi[0]) begin
                d.acc = 1'b1; d.vec = VEC_WDOG;  d.nipl = IPL_NMI;
            end else if (!q.si && win_lvl > q.sipl) begin
                d.acc   = 1'b1;
                d.vec   = win_idx;
                d.nipl  = win_lvl;
                clr_en  = 1'b1;
                clr_idx = win_idx[SRC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign accept    = q.acc;
    assign set_iflag = q.acc;
    assign save_ps   = q.acc;
    assign vec_idx   = q.vec;
    assign new_ipl   = q.nipl;

    // R7
    accept_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.acc |=> !q.acc);

    // R5
    masked_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.acc && q.vec < VEC_W'(NSRC)) |-> (q.nipl > q.sipl && !q.si));

    // R8
    accept_after_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.acc |-> $past(q.cnt == CNT_TOP));

    // R9
    blackout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_TOP);
endmodule

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/1ps
module irq_prio_resolver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [3:0] reg_wdata = 4'h0;
    logic [3:0] reg_rdata;
    logic [15:0] src_req = '0;
    logic       nmi_reset = 1'b0, nmi_debug = 1'b0, nmi_wdog = 1'b0;
    logic [2:0] cpu_ipl = 3'd0;
    logic       cpu_iflag = 1'b0;
    logic       opfetch = 1'b0;
    logic       accept, set_iflag, save_ps;
    logic [4:0] vec_idx;
    logic [2:0] new_ipl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_prio_resolver uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .nmi_reset(nmi_reset), .nmi_debug(nmi_debug), .nmi_wdog(nmi_wdog),
        .cpu_ipl(cpu_ipl), .cpu_iflag(cpu_iflag), .opfetch(opfetch),
        .accept(accept), .vec_idx(vec_idx), .new_ipl(new_ipl),
        .set_iflag(set_iflag), .save_ps(save_ps)
    );

    typedef struct packed {
        logic [3:0] a;
        logic [2:0] la;
        logic [3:0] b;
        logic [2:0] lb;
        logic [2:0] ipl;
        logic       ifl;
        logic [2:0] nmi;   // {reset, debug, watchdog}
        logic       acc;
        logic [4:0] vec;
        logic [2:0] nipl;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{4'd5,  3'd3, 4'd9,  3'd5, 3'd0, 1'b0, 3'b000, 1'b1, 5'd9,  3'd5}, // R3
        '{4'd1,  3'd4, 4'd3,  3'd4, 3'd0, 1'b0, 3'b000, 1'b1, 5'd3,  3'd4}, // R4
        '{4'd13, 3'd6, 4'd15, 3'd6, 3'd0, 1'b0, 3'b000, 1'b1, 5'd15, 3'd6}, // R4
        '{4'd0,  3'd2, 4'd13, 3'd2, 3'd0, 1'b0, 3'b000, 1'b1, 5'd0,  3'd2}, // R4
        '{4'd7,  3'd3, 4'd8,  3'd2, 3'd3, 1'b0, 3'b000, 1'b0, 5'd0,  3'd0}, // R5
        '{4'd7,  3'd4, 4'd8,  3'd2, 3'd3, 1'b0, 3'b000, 1'b1, 5'd7,  3'd4}, // R5
        '{4'd2,  3'd7, 4'd6,  3'd1, 3'd0, 1'b1, 3'b000, 1'b0, 5'd0,  3'd0}, // R5
        '{4'd2,  3'd7, 4'd6,  3'd1, 3'd0, 1'b1, 3'b001, 1'b1, 5'd16, 3'd7}, // R6
        '{4'd0,  3'd0, 4'd1,  3'd0, 3'd7, 1'b1, 3'b111, 1'b1, 5'd18, 3'd0}, // R6
        '{4'd0,  3'd0, 4'd1,  3'd0, 3'd7, 1'b1, 3'b011, 1'b1, 5'd17, 3'd7}, // R6
        '{4'd4,  3'd0, 4'd10, 3'd0, 3'd0, 1'b0, 3'b000, 1'b0, 5'd0,  3'd0}, // R3
        '{4'd12, 3'd1, 4'd11, 3'd1, 3'd0, 1'b0, 3'b000, 1'b1, 5'd12, 3'd1}, // R4
        '{4'd14, 3'd7, 4'd0,  3'd7, 3'd6, 1'b0, 3'b000, 1'b1, 5'd0,  3'd7}  // R4
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [3:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [3:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 16; i++) wr_reg(8'h70 + 8'(i), 4'h0);
    endtask

    // opfetch high for one cycle, then sample two negedges later
    task automatic fetch_once();
        @(negedge clk);
        opfetch = 1'b1;
        @(negedge clk);
        opfetch = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] rv;
        int nacc;
        int acc_k [2];
        int acc_v [2];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd_reg(8'h70, rv);
        chk("R10 reg 0x70 after reset", rv, 0);
        rd_reg(8'h7F, rv);
        chk("R10 reg 0x7F after reset", rv, 0);
        chk("R10 accept after reset", accept, 0);

        // R1 register map
        wr_reg(8'h7A, 4'hD);
        rd_reg(8'h7A, rv);
        chk("R1 readback 0x7A", rv, 13);
        rd_reg(8'h79, rv);
        chk("R1 neighbour 0x79 untouched", rv, 0);
        rd_reg(8'h6F, rv);
        chk("R1 below range reads 0", rv, 0);
        rd_reg(8'h80, rv);
        chk("R1 above range reads 0", rv, 0);

        // R2 hardware set and software clear
        @(negedge clk); src_req[4] = 1'b1;
        @(negedge clk); src_req[4] = 1'b0;
        rd_reg(8'h74, rv);
        chk("R2 hw pulse sets flag", rv, 8);
        wr_reg(8'h74, 4'h0);
        rd_reg(8'h74, rv);
        chk("R2 software clears flag", rv, 0);
        // hardware pulse beats a simultaneous clearing write
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h75; reg_wdata = 4'h2; src_req[5] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; src_req[5] = 1'b0;
        rd_reg(8'h75, rv);
        chk("R2 hw pulse wins over write", rv, 10);

        // table of vectors
        for (int n = 0; n < NV; n++) begin
            clear_all();
            wr_reg(8'h70 + 8'(VT[n].a), {1'b1, VT[n].la});
            wr_reg(8'h70 + 8'(VT[n].b), {1'b1, VT[n].lb});
            @(negedge clk);
            cpu_ipl = VT[n].ipl; cpu_iflag = VT[n].ifl;
            {nmi_reset, nmi_debug, nmi_wdog} = VT[n].nmi;
            fetch_once();
            chk($sformatf("R3 R5 R6 vector %0d accept", n), accept, VT[n].acc);
            chk($sformatf("R7 vector %0d set_iflag", n), set_iflag, VT[n].acc);
            chk($sformatf("R7 vector %0d save_ps", n), save_ps, VT[n].acc);
            if (VT[n].acc) begin
                chk($sformatf("R4 R6 vector %0d vec_idx", n), vec_idx, VT[n].vec);
                chk($sformatf("R7 vector %0d new_ipl", n), new_ipl, VT[n].nipl);
            end
            @(negedge clk);
            chk($sformatf("R7 vector %0d pulse ends", n), accept, 0);
            {nmi_reset, nmi_debug, nmi_wdog} = 3'b000;
            cpu_ipl = 3'd0; cpu_iflag = 1'b0;
            if (VT[n].acc && VT[n].vec < 5'd16) begin
                rd_reg(8'h70 + 8'(VT[n].vec), rv);
                chk($sformatf("R7 vector %0d winner flag cleared", n), rv[3], 0);
                rd_reg(8'h70 + 8'((VT[n].vec == 5'(VT[n].a)) ? VT[n].b : VT[n].a), rv);
                chk($sformatf("R7 vector %0d loser flag kept", n), rv[3], 1);
            end
        end

        // R9 blackout: opfetch held for four cycles gives exactly two samples
        clear_all();
        wr_reg(8'h75, 4'hB);
        wr_reg(8'h76, 4'hA);
        nacc = 0;
        acc_k = '{0, 0};
        acc_v = '{0, 0};
        @(negedge clk);
        opfetch = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            if (k == 4) opfetch = 1'b0;
            if (accept) begin
                if (nacc < 2) begin
                    acc_k[nacc] = k;
                    acc_v[nacc] = vec_idx;
                end
                nacc++;
            end
        end
        chk("R9 accept count in burst", nacc, 2);
        chk("R9 first accept cycle", acc_k[0], 2);
        chk("R9 first accept vector", acc_v[0], 5);
        chk("R9 second accept cycle", acc_k[1], 5);
        chk("R9 second accept vector", acc_v[1], 6);

        // R8 frozen snapshot: later changes do not alter the pending result
        clear_all();
        wr_reg(8'h79, 4'hA);
        @(negedge clk);
        opfetch = 1'b1;
        @(negedge clk);
        opfetch = 1'b0; cpu_iflag = 1'b1; cpu_ipl = 3'd7;
        reg_wr = 1'b1; reg_addr = 8'h79; reg_wdata = 4'h0;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 accept despite later changes", accept, 1);
        chk("R8 vector from snapshot", vec_idx, 9);
        chk("R8 level from snapshot", new_ipl, 2);
        cpu_iflag = 1'b0; cpu_ipl = 3'd0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule